// File: doc/BRIEF.md
# Three-Phase Double-Buffered Output Sequencer

This block drives the six raw gate signals of a three-phase inverter bridge. Each of the U, V and W phases has a positive and a negative signal. Software writes two 6-bit patterns into a pair of buffer registers. A transfer trigger copies both patterns at once into a two-stage output shift register.

The first stage drives the phase outputs as soon as the transfer completes. The second stage takes over when the incoming one-shot pulse falls. The buffers can therefore be rewritten freely while a sequence plays out, and nothing reaches the outputs before the next trigger.

A read of either buffer address returns the matching stage of the shift register, not the buffer content. Dead-time insertion and the timers that make the one-shot pulse belong to neighbouring logic.

Top module: `tri_phase_seq`

## Requirements
- R1: While reset is asserted, and after it is released, both buffers hold 0x00. Both shift stages hold 0x3F, and phase_out is 0x3F (all six signals inactive).
- R2: A clock edge with wr_en high stores wr_data[5:0] into a buffer. wr_sel=0 selects the first buffer and wr_sel=1 selects the second. Bits 7:6 of wr_data are discarded. Pattern layout: bit0 U positive, bit1 U negative, bit2 V positive, bit3 V negative, bit4 W positive, bit5 W negative. A 0 requests the active level and a 1 the inactive level. phase_out carries these bits unchanged in the same positions.
- R3: A clock edge with xfer high loads the first buffer into stage 0 and the second buffer into stage 1. The values used are those the buffers held before that edge. From that edge on, phase_out equals stage 0.
- R4: A falling edge of pulse_in is pulse_in sampled high at one clock edge and low at the next. At the edge that samples the low level, stage 0 takes the value of stage 1, so phase_out shows the second pattern. Stage 1 keeps its value.
- R5: Buffer writes and reads never change phase_out or either stage.
- R6: If xfer is high at the same edge that detects a pulse_in fall, the transfer wins. A new transfer before the fall replaces the pending second pattern.
- R7: rd_data is combinational. rd_sel=0 gives {2'b00, stage 0} and rd_sel=1 gives {2'b00, stage 1}. It never returns the buffer content.
- R8: A rising edge of pulse_in, or a pulse_in level held high or held low, changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_sel | input | 1 | Buffer select for writes (0 first, 1 second) |
| wr_data | input | 8 | Write data, bits 5:0 used |
| rd_sel | input | 1 | Stage select for reads |
| rd_data | output | 8 | Selected shift stage, zero-padded |
| xfer | input | 1 | Transfer trigger, sampled each clock |
| pulse_in | input | 1 | One-shot pulse input |
| phase_out | output | 6 | Raw phase gate levels |

## Verification
The hardest case to reach is a transfer trigger that arrives while a second pattern is still waiting for its pulse fall. The case where the trigger lands on the very edge that detects the fall is harder still. The stimulus builds both cases directly: it raises pulse_in, then asserts xfer either one cycle before the low sample or at the same edge. A random phase then mixes writes, triggers and pulse toggles against the behavioural model, so that same-edge write-and-transfer collisions also occur many times.

// File: rtl/tri_phase_seq.sv
module tri_phase_seq #(
  parameter int DW = 8,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          xfer,
  input  logic          pulse_in,
  output logic [PW-1:0] phase_out
);
  localparam int PAD = DW - PW;
  localparam logic [PW-1:0] IDLE = {PW{1'b1}};

  logic [PW-1:0] buf0_q, buf1_q, stage0_q, stage1_q;
  logic          pulse_q;
  logic          fall;

  assign fall = pulse_q & ~pulse_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf0_q <= '0;
      buf1_q <= '0;
    end else if (wr_en) begin
      if (wr_sel) buf1_q <= wr_data[PW-1:0];
      else        buf0_q <= wr_data[PW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage0_q <= IDLE;
      stage1_q <= IDLE;
      pulse_q  <= 1'b0;
    end else begin
      pulse_q <= pulse_in;
      if (xfer) begin
        stage0_q <= buf0_q;
        stage1_q <= buf1_q;
      end else if (fall) begin
        stage0_q <= stage1_q;
      end
    end
  end

  assign phase_out = stage0_q;
  assign rd_data   = {{PAD{1'b0}}, (rd_sel ? stage1_q : stage0_q)};
endmodule

// File: rtl/tri_phase_seq_chk.sv
module tri_phase_seq_chk #(
  parameter int DW = 8,
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          xfer,
  input logic          pulse_in,
  input logic          pulse_d,
  input logic [PW-1:0] buf0,
  input logic [PW-1:0] buf1,
  input logic [PW-1:0] stage1,
  input logic [PW-1:0] phase_out,
  input logic [DW-1:0] rd_data
);
  AST_XFER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> phase_out == $past(buf0)); // R3
  AST_FALL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && pulse_d && !pulse_in) |=> phase_out == $past(stage1)); // R4
  AST_HOLD_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && !(pulse_d && !pulse_in)) |=> $stable(phase_out)); // R5
  AST_XFER_STAGE1: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> stage1 == $past(buf1)); // R6
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DW-1:PW] == '0); // R7
endmodule

bind tri_phase_seq tri_phase_seq_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer(xfer), .pulse_in(pulse_in),
  .pulse_d(pulse_q), .buf0(buf0_q), .buf1(buf1_q), .stage1(stage1_q),
  .phase_out(phase_out), .rd_data(rd_data)
);

// File: tb/test_tri_phase_seq.sv
module test_tri_phase_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0, xfer = 1'b0, pulse_in = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [5:0] phase_out;

  int checks = 0, fails = 0;
  bit done = 0;
  int mb0, mb1, ms0, ms1;
  bit mprev;

  always #10 clk = ~clk;

  tri_phase_seq i_tri_phase_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .xfer(xfer), .pulse_in(pulse_in),
    .phase_out(phase_out)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit w, bit s, int d, bit x, bit p, bit r);
    wr_en = w; wr_sel = s; wr_data = d[7:0]; xfer = x; pulse_in = p; rd_sel = r;
    @(posedge clk);
    if (x) begin ms0 = mb0; ms1 = mb1; end
    else if (mprev && !p) ms0 = ms1;
    if (w) begin if (s) mb1 = d & 8'h3F; else mb0 = d & 8'h3F; end
    mprev = p;
    @(negedge clk);
    check({tag, " phase_out"}, int'(phase_out), ms0);
    check({tag, " rd_data"}, int'(rd_data), r ? ms1 : ms0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    mb0 = 0; mb1 = 0; ms0 = 6'h3F; ms1 = 6'h3F; mprev = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset phase_out", int'(phase_out), 6'h3F);
    rst_n = 1'b1;
    cyc("R1 after reset", 0, 0, 0, 0, 0, 1);
    cyc("R1 xfer of reset buffers", 0, 0, 0, 1, 0, 0);
    check("R1 buffers zero", int'(phase_out), 0);
    cyc("R2 write b0 bit7 set", 1, 0, 8'hEA, 0, 0, 0);
    cyc("R2 write b1", 1, 1, 8'h15, 0, 0, 1);
    cyc("R5 read after write", 0, 0, 0, 0, 0, 0);
    cyc("R3 transfer", 0, 0, 0, 1, 0, 1);
    check("R3 first pattern", int'(phase_out), 6'h2A);
    cyc("R8 pulse rise", 0, 0, 0, 0, 1, 0);
    cyc("R8 pulse high", 0, 0, 0, 0, 1, 0);
    check("R8 no change on rise", int'(phase_out), 6'h2A);
    cyc("R4 pulse fall", 0, 0, 0, 0, 0, 1);
    check("R4 second pattern", int'(phase_out), 6'h15);
    cyc("R8 pulse low held", 0, 0, 0, 0, 0, 0);
    cyc("R5 write b0", 1, 0, 8'h3C, 0, 0, 0);
    cyc("R5 write b1", 1, 1, 8'h03, 0, 0, 1);
    check("R5 outputs held", int'(phase_out), 6'h15);
    cyc("R3 xfer with write", 1, 0, 8'h11, 1, 0, 0);
    check("R3 old buffer used", int'(phase_out), 6'h3C);
    cyc("R6 pulse rise", 1, 1, 8'h2D, 0, 1, 1);
    cyc("R6 retrigger", 0, 0, 0, 1, 1, 1);
    cyc("R6 fall after retrigger", 0, 0, 0, 0, 0, 0);
    check("R6 replaced second", int'(phase_out), 6'h2D);
    cyc("R6 write b0", 1, 0, 8'h0F, 0, 1, 0);
    cyc("R6 xfer on fall", 0, 0, 0, 1, 0, 1);
    check("R6 transfer wins", int'(phase_out), 6'h0F);
    cyc("R7 read stage1", 0, 0, 0, 0, 0, 1);
    cyc("R2 write ff", 1, 0, 8'hFF, 0, 0, 0);
    cyc("R2 xfer ff", 0, 0, 0, 1, 0, 0);
    check("R2 discard high bits", int'(rd_data), 6'h3F);
    for (int i = 0; i < 400; i++) begin
      int v;
      v = $urandom;
      cyc("R7 random", v[0] & v[1], v[2], v[15:8], v[3] & v[4] & v[5], v[6], v[7]);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule